// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Two-Level Table Walker

This block turns a 16-bit virtual address into a 16-bit physical address. The upper ten bits (the virtual page number) are replaced by a ten-bit frame number, and the six-bit offset within a 64-byte page passes through unchanged. Recent translations are held in a small fully associative cache of eight slots. Each slot is tagged with the 4-bit address-space identifier of the process that caused it to be loaded, so that several processes can share the cache without a flush at every context switch.

When the cache hits, the reply comes on the clock edge after the request is taken. When it misses, a walker reads two levels of page table through a memory read port whose latency can vary. It first reads a directory entry, selected by the upper five VPN bits under a directory frame supplied with the request. It then reads a leaf entry, selected by the lower five VPN bits inside the frame that the directory entry names. A valid leaf is installed in the slot that a round-robin pointer selects, and the reply is sent. An invalid entry at either level ends the walk with a fault reply. Only one request is in progress at any time. A flush input clears the cache and cancels any walk that is running.

Top module: `tlbw_top`

## Requirements
- R1: After reset no slot is valid, `reqReady` is 1 and `respValid` and `memReqValid` are 0.
- R2: A request whose VPN and current ASID match a valid slot is answered on the next edge with `respFault`=0 and `respPaddr` = {stored frame, request offset}, and no memory read is issued.
- R3: On a miss the walker issues exactly one read at {directory frame, VPN[9:5], 1'b0}. If that entry is valid, it issues a second read at {entry[9:0], VPN[4:0], 1'b0}. Each read is a single-cycle `memReqValid` pulse.
- R4: A valid leaf entry is installed with its frame bits [9:0] and the request ASID, and the reply carries {entry[9:0], offset}. A repeat of the same request then hits.
- R5: A directory entry with bit 15 clear ends the walk with `respFault`=1 after one read, and nothing is installed.
- R6: A leaf entry with bit 15 clear ends the walk with `respFault`=1 after two reads, and nothing is installed.
- R7: A slot loaded under one ASID never hits for a request made under another ASID.
- R8: A flush invalidates every slot in one cycle, so every request after it walks again.
- R9: A flush during a walk cancels it. No reply is sent for the cancelled request, and the read response still in flight is discarded rather than used by a later walk.
- R10: Fills go to slots in round-robin order, so the ninth fill after a flush evicts the first one and leaves the second.
- R11: `reqReady` is 0 from the edge that accepts a miss until the walk ends.
- R12: Read responses are accepted after any latency of one or more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots and cancel any walk |
| curAsid | input | 4 | Address-space identifier of the request |
| dirFrame | input | 10 | Frame holding the current process's page directory |
| reqValid | input | 1 | Translation request |
| reqVaddr | input | 16 | Virtual address |
| reqReady | output | 1 | Request is taken when high together with reqValid |
| respValid | output | 1 | Reply strobe |
| respPaddr | output | 16 | Physical address |
| respFault | output | 1 | Walk found an invalid entry |
| memReqValid | output | 1 | Page-table read strobe |
| memReqAddr | output | 16 | Page-table read byte address |
| memRspValid | input | 1 | Read data strobe |
| memRspData | input | 16 | Read data; bit 15 valid, bits 9:0 frame |

## Verification
The hardest case to reach is a flush that lands while a read is still outstanding. In that case the late response must be discarded and must not be taken up by the next walk. The bench starts a miss on a freshly flushed cache and raises flush in the cycle the directory read is issued. Its memory model then answers that read after a random delay. The bench confirms that no reply appears and that the same request then walks cleanly. Faulting entries come from a hashed memory image in which about one entry in eight is invalid, and random traffic over a small pool of VPNs and ASIDs produces both hits and evictions.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_TBL,
    ST_WT_TBL,
    ST_FILL,
    ST_DRAIN
  } walkState_e;

  typedef struct packed {
    logic acceptMiss;  // capture request fields, start walk
    logic hitResp;     // reply from lookup
    logic takeDir;     // capture directory entry frame
    logic takeTbl;     // capture leaf entry frame
    logic fillEntry;   // install and reply
    logic faultResp;   // reply with fault
    logic selTbl;      // read address selects leaf level
    logic clearAll;    // invalidate every slot
  } ctrlStrobe_t;

endpackage

// File: rtl/tlbw_ctrl.sv
module tlbw_ctrl
  import tlbw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        memRspValid,
  input  logic        entryOk,
  output logic        reqReady,
  output logic        memReqValid,
  output ctrlStrobe_t strb
);

  walkState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    strb         = '0;
    strb.clearAll = flush;
    strb.selTbl  = (state == ST_RD_TBL);
    reqReady     = (state == ST_IDLE) && !flush;
    memReqValid  = (state == ST_RD_DIR) || (state == ST_RD_TBL);
    unique case (state)
      ST_IDLE: begin
        if (reqValid && !flush) begin
          if (lookupHit) begin
            strb.hitResp = 1'b1;
          end else begin
            strb.acceptMiss = 1'b1;
            nextState = ST_RD_DIR;
          end
        end
      end
      ST_RD_DIR: nextState = flush ? ST_DRAIN : ST_WT_DIR;
      ST_WT_DIR: begin
        if (memRspValid) begin
          if (flush) nextState = ST_IDLE;
          else if (entryOk) begin
            strb.takeDir = 1'b1;
            nextState = ST_RD_TBL;
          end else begin
            strb.faultResp = 1'b1;
            nextState = ST_IDLE;
          end
        end else if (flush) begin
          nextState = ST_DRAIN;
        end
      end
      ST_RD_TBL: nextState = flush ? ST_DRAIN : ST_WT_TBL;
      ST_WT_TBL: begin
        if (memRspValid) begin
          if (flush) nextState = ST_IDLE;
          else if (entryOk) begin
            strb.takeTbl = 1'b1;
            nextState = ST_FILL;
          end else begin
            strb.faultResp = 1'b1;
            nextState = ST_IDLE;
          end
        end else if (flush) begin
          nextState = ST_DRAIN;
        end
      end
      ST_FILL: begin
        strb.fillEntry = !flush;
        nextState = ST_IDLE;
      end
      ST_DRAIN: if (memRspValid) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  // R3
  single_read_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R11
  busy_during_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.acceptMiss |=> !reqReady);

endmodule

// File: rtl/tlbw_dpath.sv
module tlbw_dpath
  import tlbw_pkg::*;
#(
  parameter int ASID_W  = 4,
  parameter int IDX_W   = 5,
  parameter int OFF_W   = 6,
  parameter int PFN_W   = 10,
  parameter int ENTRIES = 8,
  parameter int MEM_DW  = 16,
  localparam int VPN_W  = 2 * IDX_W,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int MEM_AW = PFN_W + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [PFN_W-1:0]  dirFrame,
  input  logic [MEM_DW-1:0] memRspData,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic              lookupHit,
  output logic              entryOk,
  output logic              respValid,
  output logic [PA_W-1:0]   respPaddr,
  output logic              respFault
);

  localparam int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int VLD_BIT = MEM_DW - 1;

  logic [ENTRIES-1:0] slotVld;
  logic [ASID_W-1:0]  slotAsid [ENTRIES];
  logic [VPN_W-1:0]   slotVpn  [ENTRIES];
  logic [PFN_W-1:0]   slotPfn  [ENTRIES];
  logic [PTR_W-1:0]   rrPtr;

  logic [VPN_W-1:0]   lVpn;
  logic [OFF_W-1:0]   lOff;
  logic [ASID_W-1:0]  lAsid;
  logic [PFN_W-1:0]   lDirFrame;
  logic [PFN_W-1:0]   lTblFrame;
  logic [PFN_W-1:0]   lPfn;

  logic [ENTRIES-1:0] matchVec;
  logic [PFN_W-1:0]   hitPfn;
  logic [VPN_W-1:0]   inVpn;

  assign inVpn = reqVaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = slotVld[g] && (slotVpn[g] == inVpn) && (slotAsid[g] == curAsid);
  end

  always_comb begin
    hitPfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) hitPfn = hitPfn | slotPfn[i];
  end

  assign lookupHit = |matchVec;
  assign entryOk   = memRspData[VLD_BIT];

  assign memReqAddr = strb.selTbl ? {lTblFrame, lVpn[IDX_W-1:0], 1'b0}
                                  : {lDirFrame, lVpn[VPN_W-1:IDX_W], 1'b0};

  // slot storage and round-robin pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVld <= '0;
      rrPtr   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        slotAsid[i] <= '0;
        slotVpn[i]  <= '0;
        slotPfn[i]  <= '0;
      end
    end else if (strb.clearAll) begin
      slotVld <= '0;
    end else if (strb.fillEntry) begin
      slotVld[rrPtr]  <= 1'b1;
      slotAsid[rrPtr] <= lAsid;
      slotVpn[rrPtr]  <= lVpn;
      slotPfn[rrPtr]  <= lPfn;
      rrPtr <= (rrPtr == PTR_W'(ENTRIES - 1)) ? '0 : rrPtr + PTR_W'(1);
    end
  end

  // walk context
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lVpn <= '0; lOff <= '0; lAsid <= '0;
      lDirFrame <= '0; lTblFrame <= '0; lPfn <= '0;
    end else begin
      if (strb.acceptMiss) begin
        lVpn      <= inVpn;
        lOff      <= reqVaddr[OFF_W-1:0];
        lAsid     <= curAsid;
        lDirFrame <= dirFrame;
      end
      if (strb.takeDir) lTblFrame <= memRspData[PFN_W-1:0];
      if (strb.takeTbl) lPfn      <= memRspData[PFN_W-1:0];
    end
  end

  // reply registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respPaddr <= '0;
      respFault <= 1'b0;
    end else begin
      respValid <= strb.hitResp | strb.fillEntry | strb.faultResp;
      respFault <= strb.faultResp;
      if (strb.hitResp)        respPaddr <= {hitPfn, reqVaddr[OFF_W-1:0]};
      else if (strb.fillEntry) respPaddr <= {lPfn, lOff};
      else                     respPaddr <= '0;
    end
  end

  // R7
  unique_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (slotVld == '0));

  // R10
  rr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEntry && !strb.clearAll) |=>
      (rrPtr == (($past(rrPtr) == PTR_W'(ENTRIES - 1)) ? '0 : $past(rrPtr) + PTR_W'(1))));

endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
  import tlbw_pkg::*;
#(
  parameter int ASID_W  = 4,
  parameter int IDX_W   = 5,
  parameter int OFF_W   = 6,
  parameter int PFN_W   = 10,
  parameter int ENTRIES = 8,
  parameter int MEM_DW  = 16,
  localparam int VA_W   = 2 * IDX_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int MEM_AW = PFN_W + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [PFN_W-1:0]  dirFrame,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  output logic              reqReady,
  output logic              respValid,
  output logic [PA_W-1:0]   respPaddr,
  output logic              respFault,
  output logic              memReqValid,
  output logic [MEM_AW-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [MEM_DW-1:0] memRspData
);

  ctrlStrobe_t strb;
  logic        lookupHit;
  logic        entryOk;

  tlbw_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .reqValid   (reqValid),
    .lookupHit  (lookupHit),
    .memRspValid(memRspValid),
    .entryOk    (entryOk),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .strb       (strb)
  );

  tlbw_dpath #(
    .ASID_W (ASID_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .PFN_W  (PFN_W),
    .ENTRIES(ENTRIES),
    .MEM_DW (MEM_DW)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqVaddr  (reqVaddr),
    .curAsid   (curAsid),
    .dirFrame  (dirFrame),
    .memRspData(memRspData),
    .memReqAddr(memReqAddr),
    .lookupHit (lookupHit),
    .entryOk   (entryOk),
    .respValid (respValid),
    .respPaddr (respPaddr),
    .respFault (respFault)
  );

  // R4
  fill_replies_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillEntry |=> (respValid && !respFault));

  // R2
  hit_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.hitResp |=> (respValid && !memReqValid));

endmodule

// File: tb/tlbw_top_tb_top.sv
module tlbw_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [3:0]  curAsid = '0;
  logic [9:0]  dirFrame = 10'h155;
  logic        reqValid = 1'b0;
  logic [15:0] reqVaddr = '0;
  logic        reqReady;
  logic        respValid;
  logic [15:0] respPaddr;
  logic        respFault;
  logic        memReqValid;
  logic [15:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [15:0] memRspData = '0;

  always #2.5 clk = ~clk;

  tlbw_top dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .curAsid(curAsid), .dirFrame(dirFrame),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqReady(reqReady),
    .respValid(respValid), .respPaddr(respPaddr), .respFault(respFault),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int compared = 0;
  int mismatched = 0;
  bit faultsOn = 1'b0;

  // memory model state
  int          rdCount = 0;
  logic [15:0] rdAddr [2];
  bit          pend = 0;
  int          pendCnt = 0;
  logic [15:0] pendAddr = '0;

  // reference cache
  bit          mVld [8];
  logic [3:0]  mAsid [8];
  logic [9:0]  mVpn [8];
  logic [9:0]  mPfn [8];
  int          mPtr = 0;

  function automatic logic [15:0] memFn(logic [15:0] a);
    logic [15:0] h;
    h = a * 16'h9E37;
    h = h ^ (h >> 7);
    memFn = {(faultsOn ? (h[2:0] != 3'd0) : 1'b1), 5'b0, h[12:3]};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < 8; i++) mVld[i] = 0;
    mPtr = 0;
  endtask

  // memory responder, random latency
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        if (pendCnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = memFn(pendAddr);
          pend = 0;
        end else pendCnt--;
      end
      if (memReqValid) begin
        pend = 1;
        pendCnt = $urandom_range(0, 4);
        pendAddr = memReqAddr;
        if (rdCount < 2) rdAddr[rdCount] = memReqAddr;
        rdCount++;
      end
    end
  end

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    modelClear();
  endtask

  // one translation, checked against the reference
  task automatic translate(logic [15:0] va, logic [3:0] asid, output bit sawMiss);
    bit expHit; logic [9:0] expPfn; logic [9:0] vpn;
    logic [15:0] pdeA, pde, pteA, pte; bit expFault; int expReads; int waitN;
    vpn = va[15:6];
    expHit = 0; expPfn = '0;
    for (int i = 0; i < 8; i++)
      if (mVld[i] && mVpn[i] == vpn && mAsid[i] == asid) begin expHit = 1; expPfn = mPfn[i]; end
    pdeA = {dirFrame, vpn[9:5], 1'b0};
    pde = memFn(pdeA);
    pteA = {pde[9:0], vpn[4:0], 1'b0};
    pte = memFn(pteA);
    expFault = !pde[15] || !pte[15];
    expReads = pde[15] ? 2 : 1;
    waitN = 0;
    @(negedge clk);
    while (!reqReady && waitN < 100) begin @(negedge clk); waitN++; end
    reqValid = 1'b1; reqVaddr = va; curAsid = asid; rdCount = 0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (expHit) begin
      chk(respValid && !respFault, "R2 hit reply next edge", {respValid, respFault}, 2'b10);
      chk(respPaddr == {expPfn, va[5:0]}, "R2 hit paddr", respPaddr, {expPfn, va[5:0]});
      sawMiss = 0;
    end else begin
      chk(!respValid && !reqReady, "R11 busy during walk", {respValid, reqReady}, 2'b00);
      waitN = 0;
      while (!respValid && waitN < 200) begin @(negedge clk); waitN++; end
      chk(respValid, "R12 walk completes", respValid, 1);
      chk(rdCount == expReads, "R3 read count", rdCount, expReads);
      chk(rdAddr[0] == pdeA, "R3 directory address", rdAddr[0], pdeA);
      if (pde[15]) chk(rdAddr[1] == pteA, "R3 leaf address", rdAddr[1], pteA);
      if (expFault) begin
        chk(respFault, pde[15] ? "R6 leaf fault" : "R5 directory fault", respFault, 1);
      end else begin
        chk(!respFault && respPaddr == {pte[9:0], va[5:0]}, "R4 fill reply",
            {respFault, respPaddr}, {1'b0, pte[9:0], va[5:0]});
        mVld[mPtr] = 1; mAsid[mPtr] = asid; mVpn[mPtr] = vpn; mPfn[mPtr] = pte[9:0];
        mPtr = (mPtr + 1) % 8;
      end
      sawMiss = 1;
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    bit m; logic [15:0] pool [16]; logic [15:0] va;
    void'($urandom(32'd20240611));
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady && !respValid && !memReqValid, "R1 reset outputs",
        {reqReady, respValid, memReqValid}, 3'b100);

    // R4 miss then hit
    translate(16'h1234, 4'd1, m);
    chk(m, "R4 first access walks", m, 1);
    translate(16'h1239, 4'd1, m);
    chk(!m, "R4 repeat hits", m, 0);

    // R7 other ASID misses
    translate(16'h1234, 4'd2, m);
    chk(m, "R7 foreign ASID misses", m, 1);

    // R8 flush forces walks
    doFlush();
    translate(16'h1234, 4'd1, m);
    chk(m, "R8 walk after flush", m, 1);

    // R10 round robin eviction
    doFlush();
    for (int i = 0; i < 9; i++) translate({i[9:0] + 10'h040, 6'h05}, 4'd5, m);
    translate({10'h040, 6'h05}, 4'd5, m);
    chk(m, "R10 oldest evicted", m, 1);
    translate({10'h042, 6'h05}, 4'd5, m);
    chk(!m, "R10 later slot kept", m, 0);

    // R5 and R6 faults: search for addresses giving each kind
    faultsOn = 1'b1;
    doFlush();
    for (int v = 0; v < 64; v++) begin
      logic [15:0] d;
      d = memFn({dirFrame, v[4:0], 1'b0});
      if (!d[15]) begin
        translate({v[4:0], 5'd3, 6'd0}, 4'd3, m);
        translate({v[4:0], 5'd3, 6'd0}, 4'd3, m);
        chk(m, "R5 nothing installed", m, 1);
        break;
      end
    end
    for (int v = 0; v < 1024; v++) begin
      logic [15:0] d, t;
      d = memFn({dirFrame, v[9:5], 1'b0});
      t = memFn({d[9:0], v[4:0], 1'b0});
      if (d[15] && !t[15]) begin
        translate({v[9:0], 6'd1}, 4'd3, m);
        translate({v[9:0], 6'd1}, 4'd3, m);
        chk(m, "R6 nothing installed", m, 1);
        break;
      end
    end

    // R9 flush during walk
    faultsOn = 1'b0;
    doFlush();
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = 16'hABCD; curAsid = 4'd7;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(memReqValid, "R9 read issued before flush", memReqValid, 1);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    modelClear();
    begin
      bit seen; seen = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (respValid) seen = 1; end
      chk(!seen, "R9 no reply for cancelled walk", seen, 0);
    end
    translate(16'hABCD, 4'd7, m);
    chk(m, "R9 clean walk after cancel", m, 1);

    // random traffic
    faultsOn = 1'b1;
    for (int i = 0; i < 16; i++) pool[i] = 16'($urandom);
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 24) == 0) doFlush();
      va = {pool[$urandom_range(0, 15)][15:6], 6'($urandom)};
      translate(va, 4'($urandom_range(0, 3)), m);
    end

    finishRun();
  end

endmodule